// File: doc/BRIEF.md
# SD Command Issue Engine

This block formats one SD/MMC command and issues it. The requester presents the command fields on a single strobe: index, argument, response kind, check enables, data flags and block count. If the block is idle and the data path is not busy, it packs these fields into a command word and a block word. It holds the argument and sends a one-cycle start pulse to a line-level serializer.

The serializer shifts the command out, collects any response and signals completion, a timeout or a CRC failure. The engine stores the response as 32-bit words and raises sticky status flags, which software clears by writing ones. On a timeout it also pulses a reset toward the command path. CRC7 generation and pin driving belong to the serializer and are not modelled here.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, the command word, block word, argument, response words, status, start pulse, path-reset pulse and command-inhibit flag are all zero.
- R2: An accepted request sets the command word in the next cycle, with these fields:
  - the index in bits 29:24;
  - the response kind in bits 1:0 (00 none, 01 136-bit, 10 48-bit, 11 48-bit with busy);
  - the CRC check enable in bit 3 and the index check enable in bit 4;
  - data present in bit 5;
  - read direction in bit 6, set only when data is present;
  - multi-block select in bit 7 and block-count enable in bit 8, both set only for a multi-block data command.
  - All other bits are zero, and the argument is held on its own output.
- R3: When the response kind is 136-bit, bit 4 of the command word is zero whatever the index check request says.
- R4: A request is ignored while the command-inhibit flag or the data-busy input is high. No start pulse follows, and the command word keeps its value.
- R5: The start pulse is high for exactly one cycle, in the cycle after an accepted request.
- R6: The block word is set as follows:
  - for a multi-block data command, 512 in bits 15:0 and the block count in bits 31:16;
  - for a single-block data command, 512 in bits 15:0 and zero above;
  - for a command without data, zero.
- R7: On completion without timeout of a 136-bit command, the response output takes all four serializer words, with the least significant word at bits 31:0.
- R8: On completion without timeout of a 48-bit command, word 0 takes the low 32 response bits and words 1 to 3 become zero. A command with no response, or one that times out, leaves the response output unchanged.
- R9: Completion without timeout sets status bit 0 (complete). A CRC failure sets status bit 2 only when the issued command had its CRC check enabled.
- R10: Completion with timeout sets status bit 1 and not bit 0. It also gives a one-cycle path-reset pulse in the next cycle.
- R11: Status bits are write-one-to-clear. A clear strobe clears each bit whose clear-mask bit is one and leaves the others unchanged. A mask of all ones clears every bit.
- R12: The command-inhibit flag is high from the start-pulse cycle through the cycle in which completion is reported. It is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command-word write strobe |
| req_idx | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp_kind | input | 2 | Response kind selector |
| req_crc_chk | input | 1 | Enable response CRC check |
| req_idx_chk | input | 1 | Enable response index check |
| req_data | input | 1 | Data transfer follows |
| req_read | input | 1 | Data direction is card to host |
| req_multi | input | 1 | Multi-block transfer |
| req_blk_cnt | input | 16 | Block count for multi-block transfer |
| data_busy | input | 1 | Data path busy (data inhibit) |
| ser_done | input | 1 | Serializer finished the command |
| ser_timeout | input | 1 | Serializer saw no response (valid with ser_done) |
| ser_crc_err | input | 1 | Serializer response CRC failure (valid with ser_done) |
| ser_rsp | input | 128 | Response bits from serializer, LSB first |
| cmd_word | output | 32 | Packed command word |
| blk_word | output | 32 | Block size and count word |
| arg_out | output | 32 | Held argument |
| ser_start | output | 1 | One-cycle start pulse to serializer |
| cmd_inhibit | output | 1 | Command in flight |
| rsp_words | output | 128 | Captured response, word i at bits 32i+31:32i |
| status | output | 3 | Sticky flags: 0 complete, 1 timeout, 2 CRC error |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr | input | 3 | Write-one-to-clear mask |
| cmd_path_rst | output | 1 | One-cycle command path reset after a timeout |

## Verification
Suppose the engine's idea of whether a command is in flight goes wrong. The inhibit flag then shows it the cycle after the fault, and so does a start pulse for a request that should have been refused. A stale response kind or CRC-enable flag would show only at completion. It would appear as response words filled or zeroed wrongly, or as a CRC status bit set or missing. The reference model checks every output on every clock, so any such error shows within one cycle of the completion.

// File: rtl/sd_cmd_pkg.sv
// Package: shared encodings and field positions for the SD command issue engine.
// Assumes: the command word layout below is decoded by the downstream serializer.
package sd_cmd_pkg;
    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    localparam int CW_RSP_LSB = 0;
    localparam int CW_CRC_BIT = 3;
    localparam int CW_ICK_BIT = 4;
    localparam int CW_DAT_BIT = 5;
    localparam int CW_RD_BIT  = 6;
    localparam int CW_MB_BIT  = 7;
    localparam int CW_BCE_BIT = 8;
    localparam int CW_IDX_LSB = 24;

    localparam int ST_DONE = 0;
    localparam int ST_TOUT = 1;
    localparam int ST_CRC  = 2;
    localparam int ST_BITS = 3;
endpackage

// File: rtl/sd_cmd_fmt.sv
// Module: combinational packing of request fields into command and block words.
// Assumes: WORD_W is wide enough for the index field at CW_IDX_LSB.
module sd_cmd_fmt
    import sd_cmd_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 16,
    parameter int WORD_W    = 32,
    parameter int BLK_BYTES = 512
) (
    input  logic [IDX_W-1:0] idx,
    input  rsp_kind_e        rsp_kind,
    input  logic             crc_chk,
    input  logic             idx_chk,
    input  logic             data,
    input  logic             read,
    input  logic             multi,
    input  logic [CNT_W-1:0] blk_cnt,
    output logic [WORD_W-1:0] cmd_w,
    output logic [WORD_W-1:0] blk_w
);
    localparam int SIZE_W = WORD_W - CNT_W;
    localparam logic [SIZE_W-1:0] BLK_SIZE = SIZE_W'(BLK_BYTES);

    // Build the command word; long responses never check the index.
    always_comb begin
        cmd_w = '0;
        cmd_w[CW_RSP_LSB +: 2]     = rsp_kind;
        cmd_w[CW_CRC_BIT]          = crc_chk;
        cmd_w[CW_ICK_BIT]          = idx_chk && (rsp_kind != RSP_LONG);
        cmd_w[CW_DAT_BIT]          = data;
        cmd_w[CW_RD_BIT]           = data && read;
        cmd_w[CW_MB_BIT]           = data && multi;
        cmd_w[CW_BCE_BIT]          = data && multi;
        cmd_w[CW_IDX_LSB +: IDX_W] = idx;
    end

    // Build the block word from the transfer shape.
    always_comb begin
        if (!data)
            blk_w = '0;
        else if (multi)
            blk_w = {blk_cnt, BLK_SIZE};
        else
            blk_w = {{CNT_W{1'b0}}, BLK_SIZE};
    end
endmodule

// File: rtl/sd_cmd_seq.sv
// Module: issue sequencer, idle/in-flight tracking with start and path-reset pulses.
// Assumes: the serializer reports ser_done only after it has seen the start pulse.
module sd_cmd_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic data_busy,
    input  logic ser_done,
    input  logic ser_timeout,
    output logic accept,
    output logic done_evt,
    output logic busy,
    output logic start,
    output logic path_rst
);
    typedef enum logic {S_IDLE, S_FLIGHT} seq_state_e;
    seq_state_e state;

    assign accept   = req_valid && (state == S_IDLE) && !data_busy;
    assign done_evt = ser_done && (state == S_FLIGHT);
    assign busy     = (state == S_FLIGHT);

    // Move between idle and in-flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else if (accept)
            state <= S_FLIGHT;
        else if (done_evt)
            state <= S_IDLE;
    end

    // Register the one-cycle start and timeout path-reset pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start    <= 1'b0;
            path_rst <= 1'b0;
        end else begin
            start    <= accept;
            path_rst <= done_evt && ser_timeout;
        end
    end
endmodule

// File: rtl/sd_rsp_cap.sv
// Module: response word store; long responses fill every word, short ones word 0.
// Assumes: rsp_in holds the response least significant word first.
module sd_rsp_cap #(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture,
    input  logic                        long_rsp,
    input  logic [WORD_W*RSP_WORDS-1:0] rsp_in,
    output logic [WORD_W*RSP_WORDS-1:0] rsp_out
);
    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        if (w == 0) begin : g_low
            // Word 0 loads on every capture.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rsp_out[0 +: WORD_W] <= '0;
                else if (capture)
                    rsp_out[0 +: WORD_W] <= rsp_in[0 +: WORD_W];
            end
        end else begin : g_high
            // Upper words load for long responses, otherwise clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rsp_out[w*WORD_W +: WORD_W] <= '0;
                else if (capture)
                    rsp_out[w*WORD_W +: WORD_W] <= long_rsp ? rsp_in[w*WORD_W +: WORD_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sd_cmd_status.sv
// Module: sticky status flags with write-one-to-clear; a set in the same cycle wins.
// Assumes: set pulses last one cycle.
module sd_cmd_status #(
    parameter int NBITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set,
    input  logic             clr_we,
    input  logic [NBITS-1:0] clr,
    output logic [NBITS-1:0] q
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        // Hold, clear on a written one, set on an event.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else if (set[b])
                q[b] <= 1'b1;
            else if (clr_we && clr[b])
                q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/sd_cmd_issue.sv
// Module: top of the SD command issue engine: accepts a request, packs and issues it,
// then captures the response and status from the serializer.
// Assumes: ser_timeout and ser_crc_err are meaningful only while ser_done is high.
module sd_cmd_issue
    import sd_cmd_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int ARG_W     = 32,
    parameter int CNT_W     = 16,
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int BLK_BYTES = 512
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [IDX_W-1:0]            req_idx,
    input  logic [ARG_W-1:0]            req_arg,
    input  logic [1:0]                  req_rsp_kind,
    input  logic                        req_crc_chk,
    input  logic                        req_idx_chk,
    input  logic                        req_data,
    input  logic                        req_read,
    input  logic                        req_multi,
    input  logic [CNT_W-1:0]            req_blk_cnt,
    input  logic                        data_busy,
    input  logic                        ser_done,
    input  logic                        ser_timeout,
    input  logic                        ser_crc_err,
    input  logic [WORD_W*RSP_WORDS-1:0] ser_rsp,
    output logic [WORD_W-1:0]           cmd_word,
    output logic [WORD_W-1:0]           blk_word,
    output logic [ARG_W-1:0]            arg_out,
    output logic                        ser_start,
    output logic                        cmd_inhibit,
    output logic [WORD_W*RSP_WORDS-1:0] rsp_words,
    output logic [ST_BITS-1:0]          status,
    input  logic                        stat_clr_we,
    input  logic [ST_BITS-1:0]          stat_clr,
    output logic                        cmd_path_rst
);
    logic              accept, done_evt;
    logic [WORD_W-1:0] cmd_next, blk_next;
    rsp_kind_e         kind_q;
    logic              crc_en_q;
    logic              capture;
    logic [ST_BITS-1:0] st_set;

    sd_cmd_fmt #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .WORD_W(WORD_W), .BLK_BYTES(BLK_BYTES)
    ) fmt_i (
        .idx(req_idx), .rsp_kind(rsp_kind_e'(req_rsp_kind)),
        .crc_chk(req_crc_chk), .idx_chk(req_idx_chk), .data(req_data),
        .read(req_read), .multi(req_multi), .blk_cnt(req_blk_cnt),
        .cmd_w(cmd_next), .blk_w(blk_next)
    );

    sd_cmd_seq seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .data_busy(data_busy),
        .ser_done(ser_done), .ser_timeout(ser_timeout), .accept(accept),
        .done_evt(done_evt), .busy(cmd_inhibit), .start(ser_start),
        .path_rst(cmd_path_rst)
    );

    // Latch the issued command and what the completion handling needs from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= '0;
            blk_word <= '0;
            arg_out  <= '0;
            kind_q   <= RSP_NONE;
            crc_en_q <= 1'b0;
        end else if (accept) begin
            cmd_word <= cmd_next;
            blk_word <= blk_next;
            arg_out  <= req_arg;
            kind_q   <= rsp_kind_e'(req_rsp_kind);
            crc_en_q <= req_crc_chk;
        end
    end

    assign capture = done_evt && !ser_timeout && (kind_q != RSP_NONE);

    sd_rsp_cap #(.WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) cap_i (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .long_rsp(kind_q == RSP_LONG), .rsp_in(ser_rsp), .rsp_out(rsp_words)
    );

    // Map completion outcomes onto status events.
    always_comb begin
        st_set          = '0;
        st_set[ST_DONE] = done_evt && !ser_timeout;
        st_set[ST_TOUT] = done_evt && ser_timeout;
        st_set[ST_CRC]  = done_evt && !ser_timeout && ser_crc_err && crc_en_q;
    end

    sd_cmd_status #(.NBITS(ST_BITS)) stat_i (
        .clk(clk), .rst_n(rst_n), .set(st_set), .clr_we(stat_clr_we),
        .clr(stat_clr), .q(status)
    );
endmodule

// File: rtl/sd_cmd_issue_chk.sv
// Module: protocol checks on the issue engine's ports, bound into every instance.
// Assumes: default parameters for the field positions checked.
module sd_cmd_issue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ser_start,
    input logic        cmd_inhibit,
    input logic        data_busy,
    input logic        ser_done,
    input logic        ser_timeout,
    input logic [31:0] cmd_word,
    input logic [31:0] blk_word,
    input logic [2:0]  status,
    input logic        cmd_path_rst
);
    // R5
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_start);
    // R4
    no_start_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inhibit || data_busy) |=> !ser_start);
    // R12
    inhibit_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> cmd_inhibit);
    // R10
    timeout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inhibit && ser_done && ser_timeout) |=> (cmd_path_rst && status[1]));
    // R9
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inhibit && ser_done && !ser_timeout) |=> status[0]);
    // R3
    long_no_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_start && cmd_word[1:0] == 2'b01) |-> !cmd_word[4]);
    // R6
    multi_block_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_start && cmd_word[7]) |-> (blk_word[15:0] == 16'd512));
endmodule

bind sd_cmd_issue sd_cmd_issue_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ser_start(ser_start), .cmd_inhibit(cmd_inhibit),
    .data_busy(data_busy), .ser_done(ser_done), .ser_timeout(ser_timeout),
    .cmd_word(cmd_word), .blk_word(blk_word), .status(status),
    .cmd_path_rst(cmd_path_rst)
);

// File: tb/sd_cmd_issue_tb_top.sv
module sd_cmd_issue_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         req_valid = 0, req_crc_chk = 0, req_idx_chk = 0;
    logic         req_data = 0, req_read = 0, req_multi = 0;
    logic [5:0]   req_idx = 0;
    logic [31:0]  req_arg = 0;
    logic [1:0]   req_rsp_kind = 0;
    logic [15:0]  req_blk_cnt = 0;
    logic         data_busy = 0, ser_done = 0, ser_timeout = 0, ser_crc_err = 0;
    logic [127:0] ser_rsp = 0;
    logic         stat_clr_we = 0;
    logic [2:0]   stat_clr = 0;
    logic [31:0]  cmd_word, blk_word, arg_out;
    logic         ser_start, cmd_inhibit, cmd_path_rst;
    logic [127:0] rsp_words;
    logic [2:0]   status;

    sd_cmd_issue dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .req_arg(req_arg), .req_rsp_kind(req_rsp_kind), .req_crc_chk(req_crc_chk),
        .req_idx_chk(req_idx_chk), .req_data(req_data), .req_read(req_read),
        .req_multi(req_multi), .req_blk_cnt(req_blk_cnt), .data_busy(data_busy),
        .ser_done(ser_done), .ser_timeout(ser_timeout), .ser_crc_err(ser_crc_err),
        .ser_rsp(ser_rsp), .cmd_word(cmd_word), .blk_word(blk_word),
        .arg_out(arg_out), .ser_start(ser_start), .cmd_inhibit(cmd_inhibit),
        .rsp_words(rsp_words), .status(status), .stat_clr_we(stat_clr_we),
        .stat_clr(stat_clr), .cmd_path_rst(cmd_path_rst)
    );

    int n_cmp = 0, n_bad = 0;
    bit cmp_en = 0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Reference model: behavioural, updated on each rising edge from the port inputs.
    logic [31:0]  m_cw = 0, m_blk = 0, m_arg = 0;
    logic [127:0] m_rsp = 0;
    logic [2:0]   m_st = 0;
    logic         m_start = 0, m_rst = 0, m_busy = 0, m_crc = 0;
    logic [1:0]   m_kind = 0;

    always @(posedge clk) begin
        bit acc;
        if (!rst_n) begin
            m_cw = 0; m_blk = 0; m_arg = 0; m_rsp = 0; m_st = 0;
            m_start = 0; m_rst = 0; m_busy = 0; m_crc = 0; m_kind = 0;
        end else begin
            acc = req_valid && !m_busy && !data_busy;
            m_start = acc;
            m_rst = 0;
            if (stat_clr_we) m_st = m_st & ~stat_clr;
            if (m_busy && ser_done) begin
                m_busy = 0;
                if (ser_timeout) begin
                    m_st[1] = 1; m_rst = 1;
                end else begin
                    m_st[0] = 1;
                    if (ser_crc_err && m_crc) m_st[2] = 1;
                    if (m_kind == 2'b01) m_rsp = ser_rsp;
                    else if (m_kind != 2'b00) m_rsp = {96'd0, ser_rsp[31:0]};
                end
            end
            if (acc) begin
                m_busy = 1;
                m_kind = req_rsp_kind;
                m_crc  = req_crc_chk;
                m_arg  = req_arg;
                m_cw = 32'(req_idx) * 32'h0100_0000 + 32'(req_rsp_kind)
                     + (req_crc_chk ? 32'h8 : 0)
                     + ((req_idx_chk && req_rsp_kind != 2'b01) ? 32'h10 : 0)
                     + (req_data ? 32'h20 : 0)
                     + ((req_data && req_read) ? 32'h40 : 0)
                     + ((req_data && req_multi) ? 32'h180 : 0);
                m_blk = !req_data ? 32'd0 :
                        req_multi ? 32'(req_blk_cnt) * 32'h1_0000 + 32'd512 : 32'd512;
            end
        end
    end

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2", "cmd_word", 128'(cmd_word), 128'(m_cw));
            chk("R2", "arg_out", 128'(arg_out), 128'(m_arg));
            chk("R6", "blk_word", 128'(blk_word), 128'(m_blk));
            chk("R5", "ser_start", 128'(ser_start), 128'(m_start));
            chk("R12", "cmd_inhibit", 128'(cmd_inhibit), 128'(m_busy));
            chk("R7", "rsp_words", rsp_words, m_rsp);
            chk("R9", "status", 128'(status), 128'(m_st));
            chk("R10", "cmd_path_rst", 128'(cmd_path_rst), 128'(m_rst));
        end
    end

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [1:0] kind, input logic crc, input logic ick,
                         input logic dat, input logic rd, input logic mb,
                         input logic [15:0] cnt);
        @(negedge clk);
        req_valid = 1; req_idx = idx; req_arg = arg; req_rsp_kind = kind;
        req_crc_chk = crc; req_idx_chk = ick; req_data = dat; req_read = rd;
        req_multi = mb; req_blk_cnt = cnt;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_cmd(input logic to, input logic ce, input logic [127:0] r);
        @(negedge clk); @(negedge clk);
        ser_done = 1; ser_timeout = to; ser_crc_err = ce; ser_rsp = r;
        @(negedge clk);
        ser_done = 0; ser_timeout = 0; ser_crc_err = 0;
        @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        stat_clr_we = 1; stat_clr = m;
        @(negedge clk);
        stat_clr_we = 0; stat_clr = 0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] cw_hold;
        logic [127:0] r_hold;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        // R1: reset state
        chk("R1", "cmd_word", 128'(cmd_word), 0);
        chk("R1", "status", 128'(status), 0);
        chk("R1", "rsp_words", rsp_words, 0);
        chk("R1", "start/inhibit/rst", 128'({ser_start, cmd_inhibit, cmd_path_rst}), 0);

        // Short response, single-block read
        issue(6'd17, 32'h0000_1234, 2'b10, 1, 1, 1, 1, 0, 16'd0);
        finish_cmd(0, 0, {96'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF, 32'h1357_9BDF});
        // R8: upper words cleared on a short response
        chk("R8", "rsp_hi", rsp_words[127:32], 0);
        chk("R8", "rsp_lo", 128'(rsp_words[31:0]), 128'(32'h1357_9BDF));

        // Long response with index check requested
        issue(6'd2, 32'h0, 2'b01, 1, 1, 0, 0, 0, 16'd0);
        // R3: index check forced off
        chk("R3", "idx_chk_bit", 128'(cmd_word[4]), 0);
        cw_hold = cmd_word;
        // R4: request during flight is ignored
        issue(6'd9, 32'hDEAD_BEEF, 2'b10, 0, 0, 0, 0, 0, 16'd0);
        chk("R4", "cmd_word_held", 128'(cmd_word), 128'(cw_hold));
        finish_cmd(0, 0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        chk("R7", "rsp_long", rsp_words, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);

        // R4: data path busy holds off issue
        data_busy = 1;
        issue(6'd13, 32'h5, 2'b10, 1, 1, 0, 0, 0, 16'd0);
        chk("R4", "no_start_data_busy", 128'({ser_start, cmd_inhibit}), 0);
        data_busy = 0;

        // Multi-block write, busy response
        issue(6'd25, 32'h0000_0800, 2'b11, 1, 1, 1, 0, 1, 16'd7);
        chk("R6", "blk_word_multi", 128'(blk_word), 128'(32'h0007_0200));
        finish_cmd(0, 0, 128'h55);

        clear(3'b111);
        // Timeout: no capture, flag and path reset
        r_hold = rsp_words;
        issue(6'd8, 32'h1AA, 2'b10, 1, 1, 0, 0, 0, 16'd0);
        finish_cmd(1, 0, 128'hFFFF);
        chk("R10", "timeout_flags", 128'(status), 128'(3'b010));
        chk("R8", "rsp_kept_on_timeout", rsp_words, r_hold);

        // CRC error with and without check enabled
        clear(3'b111);
        issue(6'd3, 32'h0, 2'b10, 0, 0, 0, 0, 0, 16'd0);
        finish_cmd(0, 1, 128'h77);
        chk("R9", "crc_ignored", 128'(status), 128'(3'b001));
        issue(6'd7, 32'h0, 2'b10, 1, 1, 0, 0, 0, 16'd0);
        finish_cmd(0, 1, 128'h88);
        chk("R9", "crc_flagged", 128'(status), 128'(3'b101));

        // No-response command leaves response words unchanged
        r_hold = rsp_words;
        issue(6'd0, 32'h0, 2'b00, 0, 0, 0, 0, 0, 16'd0);
        finish_cmd(0, 0, 128'hBAD);
        chk("R8", "rsp_kept_no_rsp", rsp_words, r_hold);

        // R11: partial then full write-one-to-clear
        clear(3'b001);
        chk("R11", "partial_clear", 128'(status), 128'(3'b100));
        clear(3'b111);
        chk("R11", "full_clear", 128'(status), 0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule